// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the addressing core of one DMA channel. Software arms it with a request-select code, a source base address, a destination base address, two increment-enable flags, a byte count and a burst size. It then issues read beats in bursts and steps the source address and the remaining byte count on every accepted beat. Separately, it steps the destination address on every write strobe that the channel's FIFO drain logic reports.

The request-select code decides the transfer direction. A code of zero is a memory-to-memory copy, and both programmed increment flags apply. A receive code names a peripheral receive FIFO as the source, so the source increment is forced off. A transmit code names a peripheral transmit FIFO as the destination, so the destination increment is forced off. When the count runs out, the channel stops and raises a sticky count-to-zero flag. An unrecognised code raises a configuration error, and the channel stays idle.

Each transfer unit is one byte. The burst size is held as size minus one in a 5-bit field, which gives bursts of 1 to 32 beats.

Top module: `dmaeng_channel`

## Requirements
- R1: On `start` while idle, `req_sel` is decoded. 0x00 gives `xfer_kind`=0 (memory-to-memory). 0x01, 0x02, 0x04, 0x05, 0x07 and 0x08 give `xfer_kind`=1 (receive). The same values with bit 5 set (0x21, 0x22, 0x24, 0x25, 0x27, 0x28) give `xfer_kind`=2 (transmit). Any other code sets `cfg_err`=1 and `xfer_kind`=3, and the channel stays idle (`busy`=0, `rd_req`=0). A valid start clears `cfg_err`.
- R2: For a memory-to-memory transfer, the source and destination increments follow `src_inc` and `dst_inc` as programmed.
- R3: For a receive transfer, `src_addr` stays at `src_base` whatever `src_inc` is, and the destination increment follows `dst_inc`.
- R4: For a transmit transfer, `dst_addr` stays at `dst_base` whatever `dst_inc` is, and the source increment follows `src_inc`.
- R5: A beat is accepted when `rd_req` and `rd_ack` are both 1. After each accepted beat, `src_addr` increases by 1 if the effective source increment is on.
- R6: After a valid start, `bytes_left` is `byte_count`. It decreases by 1 after each accepted beat.
- R7: A burst has `burst_m1`+1 beats. `rd_last` is 1 on the final beat of a burst. After a burst that does not finish the transfer, `rd_req` is 0 for exactly one cycle before the next burst begins.
- R8: A burst ends early, with `rd_last`=1, on the beat that brings `bytes_left` to zero.
- R9: In the cycle after the final decrement, `ctz`=1, `busy`=0 and `rd_req`=0. `ctz` is 0 while `busy` is 1. `ctz` holds until the next start.
- R10: After a valid start, `dst_addr` is `dst_base`. Each cycle with `wr_stb`=1 increases it by 1 if the effective destination increment is on.
- R11: A valid start with `byte_count`=0 issues no read beats and sets `ctz`=1 in the next cycle.
- R12: `start` while `busy`=1 is ignored. Addresses, count and the burst sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Arm pulse; sampled only while idle |
| req_sel | input | 6 | Request-select code |
| src_base | input | AW | Programmed source address |
| dst_base | input | AW | Programmed destination address |
| src_inc | input | 1 | Programmed source increment enable |
| dst_inc | input | 1 | Programmed destination increment enable |
| byte_count | input | CW | Bytes to move before count-to-zero |
| burst_m1 | input | BW | Burst size minus one |
| rd_ack | input | 1 | Read beat accepted |
| wr_stb | input | 1 | One byte written to the destination |
| rd_req | output | 1 | Read beat requested |
| rd_last | output | 1 | Current beat ends the burst |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| bytes_left | output | CW | Remaining byte count |
| busy | output | 1 | Transfer in progress |
| ctz | output | 1 | Count reached zero (sticky) |
| cfg_err | output | 1 | Invalid request-select code at last start |
| xfer_kind | output | 2 | 0 memory, 1 receive, 2 transmit, 3 invalid |

## Verification
The read path is driven with several combinations of count, burst size and acknowledge pattern:
- a count that is not a multiple of the burst size, so the last burst ends early;
- single-byte bursts, which put a gap after every beat;
- a 32-byte burst larger than the count;
- an acknowledge held low for several cycles, which shows that beats wait for the handshake.

Receive, transmit and memory codes are each armed with both increment flags set. This separates a forced-off increment from a programmed one, and that difference shows directly in the address ports. Invalid codes next to valid ones (0x03, 0x20), a zero count, and a start issued mid-transfer cover the remaining corner cases.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

  typedef enum logic [1:0] {
    XK_MEM = 2'd0,
    XK_RX  = 2'd1,
    XK_TX  = 2'd2,
    XK_BAD = 2'd3
  } xfer_kind_e;

  // Peripheral slot numbers that exist in the low nibble of a request code.
  function automatic logic periph_slot_ok(input logic [3:0] slot);
    case (slot)
      4'd1, 4'd2, 4'd4, 4'd5, 4'd7, 4'd8: periph_slot_ok = 1'b1;
      default:                            periph_slot_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dmaeng_decode.sv
module dmaeng_decode
  import dmaeng_pkg::*;
(
  input  logic [5:0]  req_sel,
  input  logic        src_inc_prog,
  input  logic        dst_inc_prog,
  output xfer_kind_e  kind,
  output logic        code_ok,
  output logic        src_inc_eff,
  output logic        dst_inc_eff
);

  always_comb begin
    kind        = XK_BAD;
    code_ok     = 1'b0;
    src_inc_eff = 1'b0;
    dst_inc_eff = 1'b0;
    if (req_sel == 6'd0) begin
      kind        = XK_MEM;
      code_ok     = 1'b1;
      src_inc_eff = src_inc_prog;
      dst_inc_eff = dst_inc_prog;
    end else if (!req_sel[4] && periph_slot_ok(req_sel[3:0])) begin
      code_ok = 1'b1;
      if (req_sel[5]) begin
        // transmit: destination is a fixed peripheral FIFO
        kind        = XK_TX;
        src_inc_eff = src_inc_prog;
      end else begin
        // receive: source is a fixed peripheral FIFO
        kind        = XK_RX;
        dst_inc_eff = dst_inc_prog;
      end
    end
  end

endmodule

// File: rtl/dmaeng_burst_seq.sv
module dmaeng_burst_seq #(
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [BW-1:0] burst_m1,
  input  logic          rd_ack,
  input  logic          cnt_one,
  output logic          rd_req,
  output logic          rd_last,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} seq_st_e;

  seq_st_e       st_q, st_n;
  logic [BW-1:0] beat_q, beat_n;
  logic [BW-1:0] len_q, len_n;
  logic          end_of_burst;

  assign end_of_burst = (beat_q == len_q);
  assign rd_req  = (st_q == S_RUN);
  assign rd_last = rd_req && (end_of_burst || cnt_one);
  assign busy    = (st_q != S_IDLE);

  always_comb begin
    st_n   = st_q;
    beat_n = beat_q;
    len_n  = len_q;
    case (st_q)
      S_IDLE: if (go) begin
        st_n   = S_RUN;
        beat_n = '0;
        len_n  = burst_m1;
      end
      S_RUN: if (rd_ack) begin
        if (cnt_one) begin
          st_n = S_IDLE;
        end else if (end_of_burst) begin
          st_n   = S_GAP;
          beat_n = '0;
        end else begin
          beat_n = beat_q + BW'(1);
        end
      end
      S_GAP: st_n = S_RUN;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      beat_q <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_n;
      beat_q <= beat_n;
      len_q  <= len_n;
    end
  end

  // R7: beat index never passes the latched burst length
  p_beat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN) |-> (beat_q <= len_q));

  // R7: a non-final burst is followed by one idle cycle
  p_gap_after_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && rd_last && !cnt_one) |=> !rd_req);

  // R8: the final byte always closes the burst
  p_last_on_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cnt_one) |-> rd_last);

endmodule

// File: rtl/dmaeng_addr_cnt.sv
module dmaeng_addr_cnt
  import dmaeng_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok,
  input  logic          load_bad,
  input  xfer_kind_e    kind_in,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] cnt_in,
  input  logic          sinc_in,
  input  logic          dinc_in,
  input  logic          beat,
  input  logic          wr_stb,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] bytes_left,
  output logic          cnt_one,
  output logic          ctz,
  output logic          cfg_err,
  output xfer_kind_e    kind
);

  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sinc_q, sinc_n, dinc_q, dinc_n;
  logic          loaded_q, loaded_n;
  logic          ctz_q, ctz_n, err_q, err_n;
  xfer_kind_e    kind_q, kind_n;
  logic          upd_en;

  assign cnt_one = (cnt_q == CW'(1));
  assign upd_en  = load_ok | load_bad | beat | wr_stb;

  always_comb begin
    src_n = src_q;   dst_n = dst_q;   cnt_n = cnt_q;
    sinc_n = sinc_q; dinc_n = dinc_q; loaded_n = loaded_q;
    ctz_n = ctz_q;   err_n = err_q;   kind_n = kind_q;
    if (load_ok) begin
      src_n    = src_base;
      dst_n    = dst_base;
      cnt_n    = cnt_in;
      sinc_n   = sinc_in;
      dinc_n   = dinc_in;
      kind_n   = kind_in;
      loaded_n = 1'b1;
      err_n    = 1'b0;
      ctz_n    = (cnt_in == '0);
    end else if (load_bad) begin
      kind_n   = XK_BAD;
      loaded_n = 1'b0;
      err_n    = 1'b1;
      ctz_n    = 1'b0;
    end else begin
      if (beat) begin
        src_n = src_q + AW'(sinc_q);
        cnt_n = cnt_q - CW'(1);
        if (cnt_one) ctz_n = 1'b1;
      end
      if (wr_stb && loaded_q && dinc_q) dst_n = dst_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;  dst_q <= '0;  cnt_q <= '0;
      sinc_q <= 1'b0; dinc_q <= 1'b0; loaded_q <= 1'b0;
      ctz_q <= 1'b0; err_q <= 1'b0; kind_q <= XK_MEM;
    end else if (upd_en) begin
      src_q <= src_n;  dst_q <= dst_n;  cnt_q <= cnt_n;
      sinc_q <= sinc_n; dinc_q <= dinc_n; loaded_q <= loaded_n;
      ctz_q <= ctz_n; err_q <= err_n; kind_q <= kind_n;
    end
  end

  assign src_addr   = src_q;
  assign dst_addr   = dst_q;
  assign bytes_left = cnt_q;
  assign ctz        = ctz_q;
  assign cfg_err    = err_q;
  assign kind       = kind_q;

  // R6: each accepted beat removes exactly one byte
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load_ok && !load_bad) |=> (bytes_left == $past(bytes_left) - CW'(1)));

  // R3: with the source increment forced or left off, the source stays put
  p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sinc_q && !load_ok && !load_bad) |=> $stable(src_addr));

  // R5: an enabled source advances by one per beat
  p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sinc_q && !load_ok && !load_bad) |=> (src_addr == $past(src_addr) + AW'(1)));

  // R9: count-to-zero is sticky until a new arm
  p_ctz_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctz && !load_ok && !load_bad) |=> ctz);

endmodule

// File: rtl/dmaeng_channel.sv
module dmaeng_channel
  import dmaeng_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    req_sel,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [CW-1:0] byte_count,
  input  logic [BW-1:0] burst_m1,
  input  logic          rd_ack,
  input  logic          wr_stb,
  output logic          rd_req,
  output logic          rd_last,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] bytes_left,
  output logic          busy,
  output logic          ctz,
  output logic          cfg_err,
  output logic [1:0]    xfer_kind
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  xfer_kind_e dec_kind, kind_q;
  logic       code_ok, sinc_eff, dinc_eff;
  logic       start_take, load_ok, load_bad, go, beat, cnt_one;

  dmaeng_decode u_decode (
    .req_sel      (req_sel),
    .src_inc_prog (src_inc),
    .dst_inc_prog (dst_inc),
    .kind         (dec_kind),
    .code_ok      (code_ok),
    .src_inc_eff  (sinc_eff),
    .dst_inc_eff  (dinc_eff)
  );

  assign start_take = start && !busy;
  assign load_ok    = start_take && code_ok;
  assign load_bad   = start_take && !code_ok;
  assign go         = load_ok && (byte_count != '0);
  assign beat       = rd_req && rd_ack;

  dmaeng_burst_seq #(.BW(BW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (go),
    .burst_m1 (burst_m1),
    .rd_ack   (rd_ack),
    .cnt_one  (cnt_one),
    .rd_req   (rd_req),
    .rd_last  (rd_last),
    .busy     (busy)
  );

  dmaeng_addr_cnt #(.AW(AW), .CW(CW)) u_path (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load_ok    (load_ok),
    .load_bad   (load_bad),
    .kind_in    (dec_kind),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .cnt_in     (byte_count),
    .sinc_in    (sinc_eff),
    .dinc_in    (dinc_eff),
    .beat       (beat),
    .wr_stb     (wr_stb),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .bytes_left (bytes_left),
    .cnt_one    (cnt_one),
    .ctz        (ctz),
    .cfg_err    (cfg_err),
    .kind       (kind_q)
  );

  assign xfer_kind = kind_q;

  // R1: a rejected code never leaves the channel running
  p_err_idle_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_err |-> !busy);

  // R9: count-to-zero only while stopped
  p_ctz_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    ctz |-> (!busy && !rd_req));

  // R12: a start during a transfer leaves the count untouched
  p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && busy && !rd_ack) |=> $stable(bytes_left));

endmodule

// File: tb/dmaeng_channel_tb.sv
module dmaeng_channel_tb;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [5:0]    req_sel;
  logic [AW-1:0] src_base, dst_base;
  logic          src_inc, dst_inc;
  logic [CW-1:0] byte_count;
  logic [BW-1:0] burst_m1;
  logic          rd_ack, wr_stb;
  logic          rd_req, rd_last, busy, ctz, cfg_err;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] bytes_left;
  logic [1:0]    xfer_kind;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmaeng_channel #(.AW(AW), .CW(CW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel),
    .src_base(src_base), .dst_base(dst_base), .src_inc(src_inc), .dst_inc(dst_inc),
    .byte_count(byte_count), .burst_m1(burst_m1), .rd_ack(rd_ack), .wr_stb(wr_stb),
    .rd_req(rd_req), .rd_last(rd_last), .src_addr(src_addr), .dst_addr(dst_addr),
    .bytes_left(bytes_left), .busy(busy), .ctz(ctz), .cfg_err(cfg_err),
    .xfer_kind(xfer_kind)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic arm(input logic [5:0] sel, input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                     input bit si, input bit di, input int n, input int blen);
    @(negedge clk);
    req_sel = sel; src_base = s0; dst_base = d0; src_inc = si; dst_inc = di;
    byte_count = CW'(n); burst_m1 = BW'(blen - 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wr_pulses(input int k);
    for (int i = 0; i < k; i++) begin
      wr_stb = 1'b1;
      @(negedge clk);
    end
    wr_stb = 1'b0;
  endtask

  // Follows the read side until busy drops; acknowledges every ae-th cycle.
  task automatic run_reads(input int n, input int blen, input bit sinc,
                           input logic [AW-1:0] s0, input int ae);
    int beat_in = 0, done = 0, remain = n, cyc = 0;
    bit gap_due = 1'b0, exp_last, ack;
    logic [AW-1:0] exp_src = s0;
    while (busy && cyc < 2000) begin
      if (gap_due) begin
        chk(!rd_req, "R7", "gap cycle rd_req", rd_req, 0);
        gap_due = 1'b0;
        rd_ack = 1'b0;
      end else begin
        chk(rd_req, "R7", "rd_req in burst", rd_req, 1);
        exp_last = (beat_in == blen - 1) || (remain == 1);
        chk(rd_last == exp_last, (remain == 1) ? "R8" : "R7", "rd_last", rd_last, exp_last);
        chk(src_addr == exp_src, "R5", "src_addr", src_addr, exp_src);
        chk(bytes_left == CW'(remain), "R6", "bytes_left", bytes_left, remain);
        chk(!ctz, "R9", "ctz while busy", ctz, 0);
        ack = (cyc % ae == 0);
        rd_ack = ack;
        if (ack) begin
          done++; remain--; exp_src = exp_src + AW'(sinc);
          if (exp_last) begin beat_in = 0; gap_due = (remain != 0); end
          else beat_in++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    rd_ack = 1'b0;
    chk(done == n, "R6", "beats issued", done, n);
    chk(ctz, "R9", "ctz after final beat", ctz, 1);
    chk(!rd_req, "R9", "rd_req after end", rd_req, 0);
    chk(bytes_left == '0, "R6", "bytes_left at end", bytes_left, 0);
    chk(src_addr == exp_src, "R5", "final src_addr", src_addr, exp_src);
  endtask

  task automatic t_reset;
    chk(!busy && !rd_req, "R9", "reset idle", {busy, rd_req}, 0);
    chk(!ctz && !cfg_err, "R1", "reset flags", {ctz, cfg_err}, 0);
  endtask

  task automatic t_mem_copy;
    arm(6'h00, 32'h100, 32'h200, 1'b1, 1'b1, 5, 2);
    chk(xfer_kind == 2'd0, "R1", "mem kind", xfer_kind, 0);
    chk(!cfg_err, "R1", "valid clears err", cfg_err, 0);
    run_reads(5, 2, 1'b1, 32'h100, 1);
    chk(src_addr == 32'h105, "R2", "mem src advanced", src_addr, 32'h105);
    wr_pulses(3);
    chk(dst_addr == 32'h203, "R10", "mem dst after 3 writes", dst_addr, 32'h203);
    chk(ctz, "R9", "ctz holds", ctz, 1);
  endtask

  task automatic t_mem_fixed_src;
    arm(6'h00, 32'h40, 32'h80, 1'b0, 1'b0, 3, 32);
    run_reads(3, 32, 1'b0, 32'h40, 1);
    chk(src_addr == 32'h40, "R2", "mem src held when off", src_addr, 32'h40);
    wr_pulses(2);
    chk(dst_addr == 32'h80, "R2", "mem dst held when off", dst_addr, 32'h80);
  endtask

  task automatic t_rx;
    arm(6'h05, 32'h4000_1000, 32'h2000_0000, 1'b1, 1'b1, 7, 32);
    chk(xfer_kind == 2'd1, "R1", "rx kind 0x05", xfer_kind, 1);
    run_reads(7, 32, 1'b0, 32'h4000_1000, 2);
    chk(src_addr == 32'h4000_1000, "R3", "rx src fixed", src_addr, 32'h4000_1000);
    wr_pulses(7);
    chk(dst_addr == 32'h2000_0007, "R3", "rx dst increments", dst_addr, 32'h2000_0007);
  endtask

  task automatic t_tx;
    arm(6'h27, 32'h2000_0100, 32'h4000_2000, 1'b1, 1'b1, 4, 1);
    chk(xfer_kind == 2'd2, "R1", "tx kind 0x27", xfer_kind, 2);
    run_reads(4, 1, 1'b1, 32'h2000_0100, 1);
    wr_pulses(4);
    chk(dst_addr == 32'h4000_2000, "R4", "tx dst fixed", dst_addr, 32'h4000_2000);
    chk(src_addr == 32'h2000_0104, "R4", "tx src increments", src_addr, 32'h2000_0104);
  endtask

  task automatic t_bad_code;
    arm(6'h03, 32'h0, 32'h0, 1'b1, 1'b1, 4, 4);
    chk(cfg_err, "R1", "0x03 rejected", cfg_err, 1);
    chk(!busy && !rd_req, "R1", "0x03 stays idle", {busy, rd_req}, 0);
    chk(xfer_kind == 2'd3, "R1", "bad kind", xfer_kind, 3);
    arm(6'h20, 32'h0, 32'h0, 1'b1, 1'b1, 4, 4);
    chk(cfg_err && !busy, "R1", "0x20 rejected", {cfg_err, busy}, 2);
    arm(6'h08, 32'h0, 32'h10, 1'b0, 1'b1, 1, 1);
    chk(!cfg_err && xfer_kind == 2'd1, "R1", "0x08 accepted", {cfg_err, xfer_kind}, 1);
    run_reads(1, 1, 1'b0, 32'h0, 1);
  endtask

  task automatic t_zero_count;
    arm(6'h21, 32'h500, 32'h600, 1'b1, 1'b0, 0, 4);
    chk(ctz, "R11", "zero count ctz", ctz, 1);
    chk(!busy && !rd_req, "R11", "zero count no reads", {busy, rd_req}, 0);
    chk(src_addr == 32'h500, "R11", "zero count src", src_addr, 32'h500);
  endtask

  task automatic t_start_busy;
    arm(6'h00, 32'h900, 32'hA00, 1'b1, 1'b1, 3, 1);
    rd_ack = 1'b0;
    @(negedge clk);
    start = 1'b1; src_base = 32'hDEAD; byte_count = CW'(9); burst_m1 = '0;
    @(negedge clk);
    start = 1'b0;
    chk(src_addr == 32'h900, "R12", "src kept on busy start", src_addr, 32'h900);
    chk(bytes_left == CW'(3), "R12", "count kept on busy start", bytes_left, 3);
    chk(rd_req && busy, "R12", "still running", {rd_req, busy}, 3);
    run_reads(3, 1, 1'b1, 32'h900, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; req_sel = '0; src_base = '0; dst_base = '0;
    src_inc = 1'b0; dst_inc = 1'b0; byte_count = '0; burst_m1 = '0;
    rd_ack = 1'b0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mem_copy();
    t_mem_fixed_src();
    t_rx();
    t_tx();
    t_bad_code();
    t_zero_count();
    t_start_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule